// File: doc/BRIEF.md
# Packed-BCD Capable 8-bit ALU

This block is the combinational arithmetic and logic unit of a small accumulator-style processor. It takes an accumulator operand `a_i`, a second (memory) operand `m_i`, the current carry `c_i`, the decimal-mode flag `dec_i` and a 4-bit operation code. In the same cycle it returns an 8-bit result, the next values of the four condition flags, and a mask naming which of those flags the operation updates. The surrounding core keeps any flag whose mask bit is clear.

Add and subtract run either in binary or in packed BCD. In decimal mode some flags are taken from intermediate values of the digit correction, or from the plain binary sum or difference, rather than from the corrected result. This matches the behaviour that existing software relies on. Unary operations (shifts, rotates, increment, decrement) act on `a_i`; the core routes whichever value it wants shifted onto that input. Compare takes the register to compare on `a_i`.

Top module: `bcd_alu`

## Requirements
- R1: Code 0 (add) with `dec_i`=0 gives result = (A+M+C) mod 256, C = bit 8 of the 9-bit sum, V = ((A^R)&~(A^M)) bit 7, N = R[7], Z = (R==0). Mask = 4'b1111. Flags and mask use the order {N,V,Z,C}, with C in bit 0.
- R2: Code 0 with `dec_i`=1 adds nibble by nibble. The low sum L = A[3:0]+M[3:0]+C gains 6 when L ≥ 10. The high partial H = A&0xF0 + M&0xF0 + (L&0xF0) gains 0x60 when H ≥ 0xA0. C = (corrected H ≥ 0x100). Result = {corrected H[7:4], L[3:0]}.
- R3: In decimal add, Z = ((A+M+C) mod 256 == 0), N = H[7], and V = ((A^H)&~(A^M)) bit 7, all using H before its correction. Mask = 4'b1111.
- R4: Code 1 (subtract) with `dec_i`=0 gives D = A−M−(1−C). Result = D mod 256, C = 1 when there is no borrow, V = ((A^M)&(A^R)) bit 7, and N and Z come from the result. Mask = 4'b1111.
- R5: Code 1 with `dec_i`=1 forms the low difference A[3:0]−M[3:0]−(1−C) and subtracts 6 from it when its bit 4 is set. It then forms the high difference A&0xF0 − M&0xF0 − (bit 4 of the adjusted low, weighted 0x10) and subtracts 0x60 when its bit 8 is set. The result joins the two. N, Z and C come from the plain binary difference. Mask = 4'b1011, so V is left alone.
- R6: Code 2 (compare) forms A−M with no carry-in. C = no borrow; N and Z come from the low 8 bits. Result = A and mask = 4'b1011.
- R7: Codes 3, 4 and 5 give A&M, A|M and A^M. N and Z come from the result, and mask = 4'b1010.
- R8: Code 12 (bit test) gives N = M[7], V = M[6], Z = ((A&M)==0) and result = A. Mask = 4'b1110.
- R9: Codes 6/7 shift A left/right, filling with 0. Codes 8/9 rotate A left/right through carry, with the old C entering bit 0 (left) or bit 7 (right). The bit shifted out becomes C. N and Z come from the result, and mask = 4'b1011.
- R10: Codes 10 and 11 give (A+1) mod 256 and (A−1) mod 256, with N and Z from the result. Mask = 4'b1010.
- R11: Every flag whose mask bit is clear reads 0. Codes 13 to 15 give result = A, flags 0 and mask 0.
- R12: `dec_i` changes only codes 0 and 1. Every other code gives the same result, flags and mask for either value of `dec_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_i | input | 8 | Accumulator / register operand |
| m_i | input | 8 | Memory operand |
| c_i | input | 1 | Carry in |
| dec_i | input | 1 | Decimal mode for add and subtract |
| op_i | input | 4 | Operation code (see requirements) |
| result_o | output | 8 | Operation result |
| flags_o | output | 4 | Next flags {N,V,Z,C} |
| mask_o | output | 4 | Flags updated by this operation, {N,V,Z,C} |

## Verification
The block holds no state. A wrong internal value shows at the ports in the same evaluation as the inputs that caused it, and never later. The hidden quantities are the adjusted low nibble and the high partial of the decimal paths. A wrong correction threshold or a borrow taken from the wrong bit shows in the result digits or in C. A flag taken from the wrong intermediate (H before or after correction, or the corrected result instead of the binary sum) shows only in N, V or Z, and only for certain operand pairs. For that reason add and subtract are compared over every operand pair, both carries and both modes.

// File: rtl/bcd_alu_pkg.sv
package bcd_alu_pkg;
  localparam int DATA_W = 8;
  localparam int NIB_W  = 4;
  localparam int FLAG_W = 4;
  localparam int OP_W   = 4;
  // flag positions in flags_o / mask_o
  localparam int FLG_C = 0;
  localparam int FLG_Z = 1;
  localparam int FLG_V = 2;
  localparam int FLG_N = 3;

  typedef enum logic [OP_W-1:0] {
    ALU_ADD = 4'd0,
    ALU_SUB = 4'd1,
    ALU_CMP = 4'd2,
    ALU_AND = 4'd3,
    ALU_OR  = 4'd4,
    ALU_XOR = 4'd5,
    ALU_SHL = 4'd6,
    ALU_SHR = 4'd7,
    ALU_ROL = 4'd8,
    ALU_ROR = 4'd9,
    ALU_INC = 4'd10,
    ALU_DEC = 4'd11,
    ALU_BIT = 4'd12
  } alu_op_e;

  localparam logic [FLAG_W-1:0] MASK_ALL = 4'b1111;
  localparam logic [FLAG_W-1:0] MASK_NZC = 4'b1011;
  localparam logic [FLAG_W-1:0] MASK_NZ  = 4'b1010;
  localparam logic [FLAG_W-1:0] MASK_NVZ = 4'b1110;
endpackage

// File: rtl/bcd_alu_arith.sv
module bcd_alu_arith
  import bcd_alu_pkg::*;
#(
  parameter int W  = DATA_W,
  parameter int NW = NIB_W
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] m_i,
  input  logic         c_i,
  input  logic         dec_i,
  input  logic         sub_i,
  input  logic         cmp_i,
  output logic [W-1:0] res_o,
  output logic         n_o,
  output logic         v_o,
  output logic         z_o,
  output logic         c_o
);
  localparam int XW = W + 2;
  localparam logic [XW-1:0] DIG_LIM = XW'(10);
  localparam logic [XW-1:0] DIG_FIX = XW'(6);
  localparam logic [XW-1:0] HI_LIM  = XW'(160);
  localparam logic [XW-1:0] HI_FIX  = XW'(96);
  localparam logic [XW-1:0] CY_LIM  = XW'(256);

  logic [W:0]    bsum, bdiff;
  logic [XW-1:0] a_lo, m_lo, a_hi, m_hi, cin_x, bor_x;
  logic [XW-1:0] d_lo, d_lo_adj, d_hi, d_hi_adj;
  logic [XW-1:0] s_lo, s_lo_adj, s_hi, s_hi_adj;
  logic [W-1:0]  dadd_res, dsub_res;
  logic          unused_bits;

  assign bsum  = {1'b0, a_i} + {1'b0, m_i} + {{W{1'b0}}, c_i};
  // compare has no carry-in
  assign bdiff = {1'b0, a_i} - {1'b0, m_i} - {{W{1'b0}}, ~c_i & ~cmp_i};

  assign a_lo  = {{(XW-NW){1'b0}}, a_i[NW-1:0]};
  assign m_lo  = {{(XW-NW){1'b0}}, m_i[NW-1:0]};
  assign a_hi  = {{(XW-W){1'b0}}, a_i[W-1:NW], {NW{1'b0}}};
  assign m_hi  = {{(XW-W){1'b0}}, m_i[W-1:NW], {NW{1'b0}}};
  assign cin_x = {{(XW-1){1'b0}}, c_i};
  assign bor_x = {{(XW-1){1'b0}}, ~c_i};

  // decimal add
  assign d_lo     = a_lo + m_lo + cin_x;
  assign d_lo_adj = (d_lo >= DIG_LIM) ? d_lo + DIG_FIX : d_lo;
  assign d_hi     = a_hi + m_hi + {d_lo_adj[XW-1:NW], {NW{1'b0}}};
  assign d_hi_adj = (d_hi >= HI_LIM) ? d_hi + HI_FIX : d_hi;
  assign dadd_res = {d_hi_adj[W-1:NW], d_lo_adj[NW-1:0]};

  // decimal subtract
  assign s_lo     = a_lo - m_lo - bor_x;
  assign s_lo_adj = s_lo[NW] ? s_lo - DIG_FIX : s_lo;
  assign s_hi     = a_hi - m_hi - {{(XW-NW-1){1'b0}}, s_lo_adj[NW], {NW{1'b0}}};
  assign s_hi_adj = s_hi[W] ? s_hi - HI_FIX : s_hi;
  assign dsub_res = {s_hi_adj[W-1:NW], s_lo_adj[NW-1:0]};

  assign unused_bits = ^{s_lo_adj[XW-1:NW+1], s_hi_adj[XW-1:W], s_hi_adj[NW-1:0]};

  always_comb begin
    if (sub_i || cmp_i) begin
      res_o = (dec_i && !cmp_i) ? dsub_res : bdiff[W-1:0];
      n_o   = bdiff[W-1];
      z_o   = (bdiff[W-1:0] == '0);
      c_o   = ~bdiff[W];
      v_o   = (a_i[W-1] ^ m_i[W-1]) & (a_i[W-1] ^ bdiff[W-1]);
    end else if (dec_i) begin
      res_o = dadd_res;
      n_o   = d_hi[W-1];
      z_o   = (bsum[W-1:0] == '0);
      c_o   = (d_hi_adj >= CY_LIM);
      v_o   = (a_i[W-1] ^ d_hi[W-1]) & ~(a_i[W-1] ^ m_i[W-1]);
    end else begin
      res_o = bsum[W-1:0];
      n_o   = bsum[W-1];
      z_o   = (bsum[W-1:0] == '0);
      c_o   = bsum[W];
      v_o   = (a_i[W-1] ^ bsum[W-1]) & ~(a_i[W-1] ^ m_i[W-1]);
    end
  end
endmodule

// File: rtl/bcd_alu_logic.sv
module bcd_alu_logic
  import bcd_alu_pkg::*;
#(
  parameter int W = DATA_W
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] m_i,
  input  alu_op_e      op_i,
  output logic [W-1:0] res_o
);
  always_comb begin
    unique case (op_i)
      ALU_AND: res_o = a_i & m_i;
      ALU_OR:  res_o = a_i | m_i;
      ALU_XOR: res_o = a_i ^ m_i;
      default: res_o = a_i & m_i;
    endcase
  end
endmodule

// File: rtl/bcd_alu_shift.sv
module bcd_alu_shift
  import bcd_alu_pkg::*;
#(
  parameter int W = DATA_W
) (
  input  logic [W-1:0] a_i,
  input  logic         c_i,
  input  alu_op_e      op_i,
  output logic [W-1:0] res_o,
  output logic         c_o
);
  always_comb begin
    c_o = c_i;
    unique case (op_i)
      ALU_SHL: begin res_o = {a_i[W-2:0], 1'b0}; c_o = a_i[W-1]; end
      ALU_SHR: begin res_o = {1'b0, a_i[W-1:1]}; c_o = a_i[0];   end
      ALU_ROL: begin res_o = {a_i[W-2:0], c_i};  c_o = a_i[W-1]; end
      ALU_ROR: begin res_o = {c_i, a_i[W-1:1]};  c_o = a_i[0];   end
      ALU_INC: res_o = a_i + W'(1);
      ALU_DEC: res_o = a_i - W'(1);
      default: res_o = a_i;
    endcase
  end
endmodule

// File: rtl/bcd_alu.sv
module bcd_alu
  import bcd_alu_pkg::*;
(
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] m_i,
  input  logic              c_i,
  input  logic              dec_i,
  input  logic [OP_W-1:0]   op_i,
  output logic [DATA_W-1:0] result_o,
  output logic [FLAG_W-1:0] flags_o,
  output logic [FLAG_W-1:0] mask_o
);
  alu_op_e           op;
  logic [DATA_W-1:0] ar_res, lg_res, sh_res;
  logic              ar_n, ar_v, ar_z, ar_c, sh_c;
  logic [FLAG_W-1:0] raw;

  assign op = alu_op_e'(op_i);

  bcd_alu_arith #(.W(DATA_W), .NW(NIB_W)) u_arith (
    .a_i   (a_i),
    .m_i   (m_i),
    .c_i   (c_i),
    .dec_i (dec_i),
    .sub_i (op == ALU_SUB),
    .cmp_i (op == ALU_CMP),
    .res_o (ar_res),
    .n_o   (ar_n),
    .v_o   (ar_v),
    .z_o   (ar_z),
    .c_o   (ar_c)
  );

  bcd_alu_logic #(.W(DATA_W)) u_logic (
    .a_i   (a_i),
    .m_i   (m_i),
    .op_i  (op),
    .res_o (lg_res)
  );

  bcd_alu_shift #(.W(DATA_W)) u_shift (
    .a_i   (a_i),
    .c_i   (c_i),
    .op_i  (op),
    .res_o (sh_res),
    .c_o   (sh_c)
  );

  always_comb begin
    result_o = a_i;
    raw      = '0;
    mask_o   = '0;
    unique case (op)
      ALU_ADD, ALU_SUB: begin
        result_o = ar_res;
        raw      = {ar_n, ar_v, ar_z, ar_c};
        mask_o   = (op == ALU_SUB && dec_i) ? MASK_NZC : MASK_ALL;
      end
      ALU_CMP: begin
        raw    = {ar_n, 1'b0, ar_z, ar_c};
        mask_o = MASK_NZC;
      end
      ALU_AND, ALU_OR, ALU_XOR: begin
        result_o = lg_res;
        raw      = {lg_res[DATA_W-1], 1'b0, (lg_res == '0), 1'b0};
        mask_o   = MASK_NZ;
      end
      ALU_SHL, ALU_SHR, ALU_ROL, ALU_ROR: begin
        result_o = sh_res;
        raw      = {sh_res[DATA_W-1], 1'b0, (sh_res == '0), sh_c};
        mask_o   = MASK_NZC;
      end
      ALU_INC, ALU_DEC: begin
        result_o = sh_res;
        raw      = {sh_res[DATA_W-1], 1'b0, (sh_res == '0), 1'b0};
        mask_o   = MASK_NZ;
      end
      ALU_BIT: begin
        raw    = {m_i[DATA_W-1], m_i[DATA_W-2], ((a_i & m_i) == '0), 1'b0};
        mask_o = MASK_NVZ;
      end
      default: ;
    endcase
  end

  assign flags_o = raw & mask_o;
endmodule

// File: rtl/bcd_alu_checker.sv
module bcd_alu_checker
  import bcd_alu_pkg::*;
(
  input logic [DATA_W-1:0] a_i,
  input logic [DATA_W-1:0] m_i,
  input logic              c_i,
  input logic              dec_i,
  input logic [OP_W-1:0]   op_i,
  input logic [DATA_W-1:0] result_o,
  input logic [FLAG_W-1:0] flags_o,
  input logic [FLAG_W-1:0] mask_o
);
  logic [DATA_W:0] chk_sum;
  assign chk_sum = {1'b0, a_i} + {1'b0, m_i} + {{DATA_W{1'b0}}, c_i};

  always_comb begin
    if (op_i == 4'd0 && !dec_i)
      assert_bin_add_R1: assert ({flags_o[FLG_C], result_o} == chk_sum)
        else $error("binary add sum/carry mismatch");
    if (op_i == 4'd0 && dec_i)
      assert_dec_add_z_R3: assert (flags_o[FLG_Z] == (chk_sum[DATA_W-1:0] == '0))
        else $error("decimal add Z not from binary sum");
    if (op_i == 4'd1 && dec_i)
      assert_dec_sub_keeps_v_R5: assert (!mask_o[FLG_V] && !flags_o[FLG_V])
        else $error("decimal subtract touches V");
    if (op_i == 4'd2)
      assert_cmp_keeps_a_R6: assert (result_o == a_i && mask_o == MASK_NZC)
        else $error("compare altered result or mask");
    if (op_i == 4'd12)
      assert_bit_test_R8: assert (result_o == a_i && flags_o[FLG_N] == m_i[DATA_W-1]
                                  && flags_o[FLG_V] == m_i[DATA_W-2])
        else $error("bit test flags wrong");
    if (op_i == 4'd8)
      assert_rol_carry_R9: assert (result_o[0] == c_i && flags_o[FLG_C] == a_i[DATA_W-1])
        else $error("rotate left carry path wrong");
    if (op_i > 4'd12)
      assert_idle_code_R11: assert (result_o == a_i && mask_o == '0 && flags_o == '0)
        else $error("unused code not inert");
    assert_unmasked_zero_R11: assert ((flags_o & ~mask_o) == '0)
      else $error("flag set outside mask");
  end
endmodule

bind bcd_alu bcd_alu_checker u_chk (.*);

// File: tb/sim_bcd_alu.sv
`timescale 1ns/100ps
module sim_bcd_alu;
  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic [7:0] a_i = '0, m_i = '0;
  logic       c_i = 1'b0, dec_i = 1'b0;
  logic [3:0] op_i = '0;
  logic [7:0] result_o;
  logic [3:0] flags_o, mask_o;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  bcd_alu u0 (.*);

  // behavioural reference; flags packed {N,V,Z,C}
  function automatic void ref_model(input int op, a, m, c, d,
                                    output int r, output int f, output int k);
    int n = 0, v = 0, z = 0, cy = 0, t, lo, hi;
    r = a; k = 0;
    case (op)
      0: begin
        k = 15;
        if (d == 0) begin
          t = a + m + c; r = t & 255; cy = t > 255;
          v = ((a ^ r) & ~(a ^ m) & 128) != 0;
          n = r >= 128; z = r == 0;
        end else begin
          z = ((a + m + c) & 255) == 0;
          lo = (a & 15) + (m & 15) + c;
          if (lo >= 10) lo += 6;
          hi = (a & 240) + (m & 240) + (lo & 240);
          n = (hi & 128) != 0;
          v = ((a ^ hi) & ~(a ^ m) & 128) != 0;
          if (hi >= 160) hi += 96;
          cy = hi >= 256;
          r = ((lo & 15) | hi) & 255;
        end
      end
      1: begin
        t = a - m - (1 - c);
        cy = (t & 256) == 0; n = (t & 128) != 0; z = (t & 255) == 0;
        if (d == 0) begin
          r = t & 255; v = ((a ^ m) & (a ^ r) & 128) != 0; k = 15;
        end else begin
          lo = (a & 15) - (m & 15) - (1 - c);
          if ((lo & 16) != 0) lo -= 6;
          hi = (a & 240) - (m & 240) - (lo & 16);
          if ((hi & 256) != 0) hi -= 96;
          r = ((lo & 15) | hi) & 255; k = 11;
        end
      end
      2: begin
        t = a - m; cy = (t & 256) == 0; n = (t & 128) != 0; z = (t & 255) == 0; k = 11;
      end
      3, 4, 5, 10, 11: begin
        case (op)
          3: r = a & m;
          4: r = a | m;
          5: r = a ^ m;
          10: r = (a + 1) & 255;
          default: r = (a + 255) & 255;
        endcase
        n = r >= 128; z = r == 0; k = 10;
      end
      6, 7, 8, 9: begin
        case (op)
          6: begin r = (a << 1) & 255; cy = a >> 7; end
          7: begin r = a >> 1; cy = a & 1; end
          8: begin r = ((a << 1) | c) & 255; cy = a >> 7; end
          default: begin r = (a >> 1) | (c << 7); cy = a & 1; end
        endcase
        n = r >= 128; z = r == 0; k = 11;
      end
      12: begin
        n = (m >> 7) & 1; v = (m >> 6) & 1; z = (a & m) == 0; k = 14;
      end
      default: ;
    endcase
    f = ((n << 3) | (v << 2) | (z << 1) | cy) & k;
  endfunction

  function automatic string tag_of(input int op, d);
    case (op)
      0: return d ? "R2/R3" : "R1";
      1: return d ? "R5" : "R4";
      2: return d ? "R6/R12" : "R6";
      3, 4, 5: return d ? "R7/R12" : "R7";
      6, 7, 8, 9: return d ? "R9/R12" : "R9";
      10, 11: return d ? "R10/R12" : "R10";
      12: return d ? "R8/R12" : "R8";
      default: return "R11";
    endcase
  endfunction

  task automatic run_vec(input int op, a, m, c, d);
    int er, ef, ek;
    op_i = op[3:0]; a_i = a[7:0]; m_i = m[7:0]; c_i = c[0]; dec_i = d[0];
    #0.5;
    ref_model(op, a, m, c, d, er, ef, ek);
    checks++;
    if (result_o !== er[7:0] || flags_o !== ef[3:0] || mask_o !== ek[3:0]) begin
      errors++;
      if (errors <= 20)
        $display("FAIL %s op=%0d a=%02h m=%02h c=%0d d=%0d: got r=%02h f=%b k=%b exp r=%02h f=%b k=%b",
                 tag_of(op, d), op, a, m, c, d, result_o, flags_o, mask_o,
                 er[7:0], ef[3:0], ek[3:0]);
    end
    #0.5;
  endtask

  initial begin
    #10 rst_ni = 1'b1;
    #0.5;
    // state after reset with idle inputs: add of zeros, R1
    run_vec(0, 0, 0, 0, 0);
    // decimal corner cases: 99+1, 58+46, 00-01, 12-21 (R2, R3, R5)
    run_vec(0, 'h99, 'h01, 0, 1);
    run_vec(0, 'h58, 'h46, 0, 1);
    run_vec(1, 'h00, 'h01, 1, 1);
    run_vec(1, 'h12, 'h21, 1, 1);
    // binary overflow corners R1 R4
    run_vec(0, 'h7f, 'h01, 0, 0);
    run_vec(1, 'h80, 'h01, 1, 0);
    // exhaustive add/subtract, both modes and carries
    for (int op = 0; op < 2; op++)
      for (int d = 0; d < 2; d++)
        for (int c = 0; c < 2; c++)
          for (int a = 0; a < 256; a++)
            for (int m = 0; m < 256; m++)
              run_vec(op, a, m, c, d);
    // remaining codes incl. unused ones, both decimal settings (R6-R12)
    for (int op = 2; op < 16; op++)
      for (int a = 0; a < 256; a++)
        for (int k = 0; k < 8; k++)
          for (int c = 0; c < 2; c++)
            for (int d = 0; d < 2; d++)
              run_vec(op, a, (a * 29 + k * 53) & 255, c, d);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (195000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired after %0d checks (expected completion)", checks);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule